// File: doc/BRIEF.md
# Overflow Exception Redirect Unit

This block is the pipeline control that turns a fault found in the execute stage into a precise exception. When a signed add or subtract in EX overflows and decode has marked that instruction as one that checks for overflow, the unit does three things in the same cycle. It cancels the instruction's register write and memory write. It turns the instructions in EX and ID into bubbles. It flushes the fetch/decode register and forces the next fetch address to a fixed handler vector. An instruction that decode flagged as undefined is handled the same way.

On the clock edge that ends the faulting cycle, the unit records the faulting instruction's EX-stage address in an exception-address register and writes a fault code into a cause register. Instructions older than the faulting one, which are already in MEM and WB, are not touched and complete normally. A stall request that arrives in the same cycle as an exception is dropped, so the redirect always wins.

Top module: `exc_redirect_unit`

## Requirements
- R1: While reset is held, the captured address reads 0, the cause reads 0, and no redirect, flush or bubble is asserted.
- R2: An exception cycle is one where the EX slot is valid and either the overflow flag and overflow-enable are both high or the undefined flag is high. In such a cycle the register-write and memory-write outputs are forced low.
- R3: In a cycle with no exception, the register-write and memory-write outputs equal their inputs, and flush, both bubbles and the redirect stay low.
- R4: An overflow flag with overflow-enable low (an unsigned operation) causes no exception.
- R5: In an exception cycle, the fetch/decode flush, the ID bubble and the EX bubble are all high in that same cycle.
- R6: In an exception cycle, the redirect is high and the vector output reads 0x80000180.
- R7: At the clock edge that ends an exception cycle, the captured-address output takes the EX-stage PC of that cycle.
- R8: At the same edge the cause output becomes 12 for an overflow and 10 for an undefined instruction. When both faults are present, 10 wins.
- R9: The stall output follows the stall request, except in an exception cycle, where it is forced low.
- R10: The captured address and the cause hold their values across every cycle without an exception.
- R11: With the EX slot marked invalid, neither fault flag causes an exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ex_valid | input | 1 | EX stage holds a real instruction |
| ex_ovf_flag | input | 1 | Signed overflow from the EX adder |
| ex_ovf_en | input | 1 | Decode marked this op as overflow-checked |
| ex_undef | input | 1 | Decode marked this op as undefined |
| ex_pc | input | 32 | Address of the instruction in EX |
| ex_regwrite_in | input | 1 | Register write request of the EX instruction |
| ex_memwrite_in | input | 1 | Memory write request of the EX instruction |
| stall_req | input | 1 | Stall request from hazard detection |
| ex_regwrite_out | output | 1 | Register write after suppression |
| ex_memwrite_out | output | 1 | Memory write after suppression |
| flush_ifid | output | 1 | Clear the fetch/decode register |
| bubble_id | output | 1 | Zero the control signals leaving ID |
| bubble_ex | output | 1 | Zero the control signals leaving EX |
| stall_out | output | 1 | Stall after exception priority |
| pc_override | output | 1 | Select the handler vector as next PC |
| pc_vector | output | 32 | Handler address |
| epc | output | 32 | Captured faulting address |
| cause | output | 5 | Captured fault code |

## Verification
The hardest cases to reach are a stall and an overflow in the same cycle, and an instruction that carries both fault flags. Neither comes from a single clean hazard, so the driver raises those inputs together on purpose and checks the stall drop and the cause priority. Two faults in consecutive cycles are driven back to back to show that the second capture overwrites the first. Idle and invalid cycles run between faults, and on each of them the captured values must hold.

// File: rtl/exc_pkg.sv
// Package: shared fault codes and widths for the exception redirect unit.
// Assumes a five-bit cause field; codes are fixed by the exception handler.
package exc_pkg;
    localparam int CAUSE_W = 5;

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_NONE  = 5'd0,
        CAUSE_UNDEF = 5'd10,
        CAUSE_OVF   = 5'd12
    } cause_e;
endpackage

// File: rtl/exc_detect.sv
// Module: exc_detect
// Decides whether the EX instruction faults and which code it carries.
// Assumes the flags are stable for the whole cycle; an undefined op
// outranks overflow because decode found it earlier.
module exc_detect
    import exc_pkg::*;
(
    input  logic   ex_valid,
    input  logic   ovf_flag,
    input  logic   ovf_en,
    input  logic   undef,
    output logic   take,
    output cause_e code
);
    logic ovf_hit;

    // Qualify the fault sources and pick the code by priority.
    always_comb begin
        ovf_hit = ex_valid & ovf_flag & ovf_en;
        take    = ovf_hit | (ex_valid & undef);
        if (ex_valid && undef) begin
            code = CAUSE_UNDEF;
        end else if (ovf_hit) begin
            code = CAUSE_OVF;
        end else begin
            code = CAUSE_NONE;
        end
    end
endmodule

// File: rtl/exc_ctrl_gate.sv
// Module: exc_ctrl_gate
// Turns a taken exception into cancel, flush, bubble and redirect controls.
// Assumes the next-PC mux gives pc_override top priority.
module exc_ctrl_gate #(
    parameter int          XLEN   = 32,
    parameter logic [31:0] VECTOR = 32'h8000_0180
) (
    input  logic            take,
    input  logic            regwrite_in,
    input  logic            memwrite_in,
    input  logic            stall_req,
    output logic            regwrite_out,
    output logic            memwrite_out,
    output logic            flush_ifid,
    output logic            bubble_id,
    output logic            bubble_ex,
    output logic            stall_out,
    output logic            pc_override,
    output logic [XLEN-1:0] pc_vector
);
    localparam logic [XLEN-1:0] VEC_W = XLEN'(VECTOR);

    // Cancel side effects, squash younger stages and steer fetch.
    always_comb begin
        regwrite_out = regwrite_in & ~take;
        memwrite_out = memwrite_in & ~take;
        flush_ifid   = take;
        bubble_id    = take;
        bubble_ex    = take;
        stall_out    = stall_req & ~take;
        pc_override  = take;
        pc_vector    = VEC_W;
    end
endmodule

// File: rtl/exc_regs.sv
// Module: exc_regs
// Holds the faulting address and the fault code; loads only on exception.
// Assumes synchronous active-low reset clears both to zero.
module exc_regs
    import exc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take,
    input  cause_e             code,
    input  logic [XLEN-1:0]    pc_in,
    output logic [XLEN-1:0]    epc_q,
    output logic [CAUSE_W-1:0] cause_q
);
    // Capture the address and code of a faulting instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epc_q   <= '0;
            cause_q <= '0;
        end else if (take) begin
            epc_q   <= pc_in;
            cause_q <= code;
        end
    end
endmodule

// File: rtl/exc_redirect_unit.sv
// Module: exc_redirect_unit (top)
// Precise exception control for faults found in EX: cancels the faulting
// write, bubbles ID/EX, flushes IF/ID, redirects fetch to the vector and
// records the faulting address and cause. Assumes MEM/WB are left alone.
module exc_redirect_unit
    import exc_pkg::*;
#(
    parameter int          XLEN   = 32,
    parameter logic [31:0] VECTOR = 32'h8000_0180
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ex_valid,
    input  logic               ex_ovf_flag,
    input  logic               ex_ovf_en,
    input  logic               ex_undef,
    input  logic [XLEN-1:0]    ex_pc,
    input  logic               ex_regwrite_in,
    input  logic               ex_memwrite_in,
    input  logic               stall_req,
    output logic               ex_regwrite_out,
    output logic               ex_memwrite_out,
    output logic               flush_ifid,
    output logic               bubble_id,
    output logic               bubble_ex,
    output logic               stall_out,
    output logic               pc_override,
    output logic [XLEN-1:0]    pc_vector,
    output logic [XLEN-1:0]    epc,
    output logic [CAUSE_W-1:0] cause
);
    logic   take;
    cause_e code;

    exc_detect u_detect (
        .ex_valid (ex_valid),
        .ovf_flag (ex_ovf_flag),
        .ovf_en   (ex_ovf_en),
        .undef    (ex_undef),
        .take     (take),
        .code     (code)
    );

    exc_ctrl_gate #(.XLEN(XLEN), .VECTOR(VECTOR)) u_gate (
        .take         (take),
        .regwrite_in  (ex_regwrite_in),
        .memwrite_in  (ex_memwrite_in),
        .stall_req    (stall_req),
        .regwrite_out (ex_regwrite_out),
        .memwrite_out (ex_memwrite_out),
        .flush_ifid   (flush_ifid),
        .bubble_id    (bubble_id),
        .bubble_ex    (bubble_ex),
        .stall_out    (stall_out),
        .pc_override  (pc_override),
        .pc_vector    (pc_vector)
    );

    exc_regs #(.XLEN(XLEN)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (take),
        .code    (code),
        .pc_in   (ex_pc),
        .epc_q   (epc),
        .cause_q (cause)
    );
endmodule

// File: rtl/exc_redirect_chk.sv
// Module: exc_redirect_chk
// Port-level properties of the redirect unit, attached with bind.
module exc_redirect_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ex_valid,
    input logic            ex_ovf_flag,
    input logic            ex_ovf_en,
    input logic            ex_undef,
    input logic [XLEN-1:0] ex_pc,
    input logic            ex_regwrite_out,
    input logic            ex_memwrite_out,
    input logic            flush_ifid,
    input logic            bubble_id,
    input logic            bubble_ex,
    input logic            stall_out,
    input logic            pc_override,
    input logic [XLEN-1:0] epc,
    input logic [4:0]      cause
);
    // R2
    ovf_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && ex_ovf_flag && ex_ovf_en) |-> (!ex_regwrite_out && !ex_memwrite_out));
    // R5
    squash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_override |-> (flush_ifid && bubble_id && bubble_ex));
    // R7
    epc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && (ex_undef || (ex_ovf_flag && ex_ovf_en))) |=> (epc == $past(ex_pc)));
    // R8
    ovf_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && !ex_undef && ex_ovf_flag && ex_ovf_en) |=> (cause == 5'd12));
    // R9
    stall_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_override |-> !stall_out);
    // R11
    invalid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_valid |-> !pc_override);
    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid == 1'b0) |=> ($stable(epc) && $stable(cause)));
endmodule

bind exc_redirect_unit exc_redirect_chk #(.XLEN(XLEN)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .ex_valid        (ex_valid),
    .ex_ovf_flag     (ex_ovf_flag),
    .ex_ovf_en       (ex_ovf_en),
    .ex_undef        (ex_undef),
    .ex_pc           (ex_pc),
    .ex_regwrite_out (ex_regwrite_out),
    .ex_memwrite_out (ex_memwrite_out),
    .flush_ifid      (flush_ifid),
    .bubble_id       (bubble_id),
    .bubble_ex       (bubble_ex),
    .stall_out       (stall_out),
    .pc_override     (pc_override),
    .epc             (epc),
    .cause           (cause)
);

// File: tb/test_exc_redirect_unit.sv
// Scoreboard bench: the driver pushes expected items, the monitor pops and compares.
module test_exc_redirect_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ex_valid = 1'b0, ex_ovf_flag = 1'b0, ex_ovf_en = 1'b0, ex_undef = 1'b0;
    logic [31:0] ex_pc = '0;
    logic        ex_regwrite_in = 1'b0, ex_memwrite_in = 1'b0, stall_req = 1'b0;
    logic        ex_regwrite_out, ex_memwrite_out, flush_ifid, bubble_id, bubble_ex;
    logic        stall_out, pc_override;
    logic [31:0] pc_vector, epc;
    logic [4:0]  cause;

    int checks = 0;
    int failures = 0;

    typedef struct {
        string       tag;
        logic        take;
        logic        rw;
        logic        mw;
        logic        stall;
        logic [31:0] epc;
        logic [4:0]  cause;
    } exp_t;

    exp_t sb[$];
    logic [31:0] m_epc = '0;
    logic [4:0]  m_cause = '0;

    always #10 clk = ~clk;

    exc_redirect_unit i_exc_redirect_unit (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus and push the predicted result.
    task automatic drive(input string tag, input logic v, input logic of, input logic oe,
                         input logic ud, input logic [31:0] pc, input logic rw,
                         input logic mw, input logic st);
        exp_t e;
        logic t;
        @(negedge clk);
        ex_valid = v; ex_ovf_flag = of; ex_ovf_en = oe; ex_undef = ud;
        ex_pc = pc; ex_regwrite_in = rw; ex_memwrite_in = mw; stall_req = st;
        t = v && ((of && oe) || ud);
        if (t) begin
            m_epc   = pc;
            m_cause = ud ? 5'd10 : 5'd12;
        end
        e.tag = tag; e.take = t; e.rw = rw && !t; e.mw = mw && !t;
        e.stall = st && !t; e.epc = m_epc; e.cause = m_cause;
        sb.push_back(e);
    endtask

    // Monitor: just after each edge, compare outputs with the oldest item.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " R6 redirect"}, {31'd0, pc_override}, {31'd0, e.take});
                check({e.tag, " R5 squash"}, {29'd0, flush_ifid, bubble_id, bubble_ex},
                      {29'd0, e.take, e.take, e.take});
                if (e.take) check({e.tag, " R6 vector"}, pc_vector, 32'h8000_0180);
                check({e.tag, " R2/R3 writes"}, {30'd0, ex_regwrite_out, ex_memwrite_out},
                      {30'd0, e.rw, e.mw});
                check({e.tag, " R9 stall"}, {31'd0, stall_out}, {31'd0, e.stall});
                check({e.tag, " R7/R10 epc"}, epc, e.epc);
                check({e.tag, " R8/R10 cause"}, {27'd0, cause}, {27'd0, e.cause});
            end
        end
    end

    // Watchdog: a hung run is a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Main sequence.
    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset epc", epc, 32'd0);
        check("R1 reset cause", {27'd0, cause}, 32'd0);
        check("R1 reset redirect", {31'd0, pc_override}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        drive("R3 plain add",       1, 0, 1, 0, 32'h0000_0040, 1, 0, 0);
        drive("R3 plain store",     1, 0, 0, 0, 32'h0000_0044, 0, 1, 0);
        drive("R2 signed ovf",      1, 1, 1, 0, 32'h0000_004C, 1, 0, 0);
        drive("R10 idle hold",      0, 0, 0, 0, 32'h0000_0050, 1, 1, 0);
        drive("R4 unsigned ovf",    1, 1, 0, 0, 32'h0000_0054, 1, 0, 0);
        drive("R8 undef op",        1, 0, 0, 1, 32'h0000_0100, 1, 0, 0);
        drive("R8 both faults",     1, 1, 1, 1, 32'h0000_0200, 1, 1, 0);
        drive("R9 stall only",      1, 0, 0, 0, 32'h0000_0204, 1, 0, 1);
        drive("R9 stall with ovf",  1, 1, 1, 0, 32'h0000_0300, 1, 0, 1);
        drive("R7 back to back",    1, 1, 1, 0, 32'h0000_0304, 0, 1, 0);
        drive("R11 invalid ovf",    0, 1, 1, 0, 32'h0000_0400, 1, 0, 0);
        drive("R11 invalid undef",  0, 0, 0, 1, 32'h0000_0404, 0, 1, 1);
        drive("R10 normal hold",    1, 0, 1, 0, 32'h0000_0408, 1, 0, 0);
        drive("R7 high address",    1, 1, 1, 0, 32'hFFFF_FFFC, 1, 0, 0);
        drive("R10 final hold",     1, 0, 0, 0, 32'h0000_0500, 0, 0, 0);
        repeat (3) @(posedge clk);
        #2;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule